// File: doc/BRIEF.md
# Shared-Adder Multicycle Integer ALU

This block is a 32-bit integer arithmetic unit built around one adder with a carry-in. That adder serves four operations. Addition and subtraction finish in a single step. Signed multiplication uses radix-2 Booth recoding. Unsigned division uses a restoring algorithm that runs in one left-shifting work register. A 3-bit opcode is held for one clock to start an operation. The unit reports its progress on a `busy` level and a one-cycle `done` pulse. All results leave through one shared 64-bit result register.

The controller is a small state machine with five states:
- `ST_IDLE` accepts new opcodes. An add or subtract completes in place, so the state does not change.
- `ST_MUL` runs one Booth round per cycle.
- `ST_DIV` runs one restoring step per cycle.
- `ST_MUL_WB` and `ST_DIV_WB` copy the finished work register into the result.

The state moves along these transitions:
- IDLE→MUL on a multiply start.
- IDLE→DIV on a divide start.
- MUL→MUL_WB and DIV→DIV_WB after the 32nd round.
- MUL_WB→IDLE and DIV_WB→IDLE unconditionally.
- Any other case holds the current state.

Top module: `shared_adder_alu`

## Requirements
- R1: Opcode 3'b001 is add, 3'b010 is subtract, 3'b110 is multiply and 3'b111 is divide. Any other code sampled while idle starts nothing: `busy` and `done` stay low and `result` keeps its value.
- R2: Add returns `op_a + op_b` modulo 2^32, sign-extended from bit 31 to 64 bits. `result` and `done` are updated at the same clock edge that samples the opcode, and `busy` stays low.
- R3: Subtract returns `op_a - op_b` modulo 2^32, formed as `op_a + ~op_b + 1` and sign-extended to 64 bits. Its timing is the same as add.
- R4: Multiply returns the full 64-bit two's-complement product of `op_a` and `op_b`. This includes the case where both operands are -2^31.
- R5: Divide treats both operands as unsigned. It returns the remainder in `result[63:32]` and the quotient in `result[31:0]`.
- R6: Divide with `op_b` equal to zero returns a quotient of all ones and a remainder equal to `op_a`.
- R7: Multiply and divide timing:
  - `busy` rises at the start edge and stays high for exactly 33 cycles.
  - `result` and `done` are updated at the 33rd edge after the start edge, which is also the edge where `busy` falls.
- R8: While `busy` is high, any opcode is ignored. The operation in flight keeps its operands and its schedule, even if `op_a` and `op_b` change.
- R9: `done` is a one-cycle pulse for each operation. `result` changes only at the edge that raises `done`, and holds otherwise.
- R10: While `rst_n` is low, `result` is zero, `busy` and `done` are low, and opcodes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 3 | Operation select, sampled as a start strobe while idle |
| op_a | input | 32 | First operand: addend, minuend, multiplier or dividend |
| op_b | input | 32 | Second operand: addend, subtrahend, multiplicand or divisor |
| result | output | 64 | Registered result of the last completed operation |
| busy | output | 1 | High while a multiply or divide is in progress |
| done | output | 1 | One-cycle pulse when `result` has just been updated |

## Verification
Each add or subtract result is checked half a cycle after its start edge, because a single register stands between the opcode and `result`. For multiply and divide, the bench follows the design cycle by cycle:
- Half a cycle after the start edge, it checks that `busy` is high and `done` is low.
- It checks again just before the 33rd edge, where `done` must still be low and the old result must still be held.
- It checks the new result and the `done` pulse just after the 33rd edge.
- It checks one cycle later that `done` has fallen and the result is held.

Ignored opcodes, both invalid codes and starts issued while busy, are checked by looking at `busy`, `done` and `result` after the next edge.

// File: rtl/alu_pkg.sv
package alu_pkg;

    // Opcode encodings sampled on the start strobe
    localparam logic [2:0] OPC_ADD = 3'b001;
    localparam logic [2:0] OPC_SUB = 3'b010;
    localparam logic [2:0] OPC_MUL = 3'b110;
    localparam logic [2:0] OPC_DIV = 3'b111;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_MUL    = 3'd1,
        ST_DIV    = 3'd2,
        ST_MUL_WB = 3'd3,
        ST_DIV_WB = 3'd4
    } alu_state_e;

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int WIDTH = 33
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    // The single carry-propagate adder shared by every operation
    assign {cout, sum} = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
endmodule

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_state_e              state,
    input  logic [2:0]              opcode,
    input  logic [DATA_W-1:0]       op_a,
    input  logic [DATA_W-1:0]       op_b,
    input  logic [2*DATA_W+1:0]     work,
    input  logic [DATA_W-1:0]       mcand,
    output logic [DATA_W:0]         add_a,
    output logic [DATA_W:0]         add_b,
    output logic                    add_cin
);
    localparam int AW     = DATA_W + 1;
    localparam int WORK_W = 2 * DATA_W + 2;

    logic [AW-1:0] mcand_ext;
    assign mcand_ext = {mcand[DATA_W-1], mcand};

    always_comb begin
        add_a   = '0;
        add_b   = '0;
        add_cin = 1'b0;
        unique case (state)
            ST_IDLE: begin
                add_a = {op_a[DATA_W-1], op_a};
                if (opcode == OPC_SUB) begin
                    add_b   = ~{op_b[DATA_W-1], op_b};
                    add_cin = 1'b1;
                end else begin
                    add_b   = {op_b[DATA_W-1], op_b};
                end
            end
            ST_MUL: begin
                // Booth pair {y_i, y_i-1} sits in the two lowest work bits
                add_a = work[WORK_W-1 -: AW];
                unique case (work[1:0])
                    2'b01: add_b = mcand_ext;
                    2'b10: begin
                        add_b   = ~mcand_ext;
                        add_cin = 1'b1;
                    end
                    default: add_b = '0;
                endcase
            end
            ST_DIV: begin
                // Shifted partial remainder minus the zero-extended divisor
                add_a   = work[2*DATA_W-1 -: AW];
                add_b   = ~{1'b0, mcand};
                add_cin = 1'b1;
            end
            ST_MUL_WB, ST_DIV_WB: begin
                add_a = '0;
            end
        endcase
    end
endmodule

// File: rtl/shared_adder_alu.sv
module shared_adder_alu
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            opcode,
    input  logic [DATA_W-1:0]     op_a,
    input  logic [DATA_W-1:0]     op_b,
    output logic [2*DATA_W-1:0]   result,
    output logic                  busy,
    output logic                  done
);
    localparam int AW     = DATA_W + 1;
    localparam int RES_W  = 2 * DATA_W;
    localparam int WORK_W = 2 * DATA_W + 2;
    localparam int STEPS  = DATA_W;
    localparam int CNT_W  = $clog2(STEPS);

    alu_state_e          state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [WORK_W-1:0]   work_q, work_d;
    logic [DATA_W-1:0]   mcand_q;
    logic [AW-1:0]       add_a, add_b, add_sum;
    logic                add_cin, add_cout;
    logic                idle, start_mul, start_div, start_short, last_step;

    assign idle        = (state_q == ST_IDLE);
    assign start_mul   = idle && (opcode == OPC_MUL);
    assign start_div   = idle && (opcode == OPC_DIV);
    assign start_short = idle && ((opcode == OPC_ADD) || (opcode == OPC_SUB));
    assign last_step   = (cnt_q == CNT_W'(STEPS - 1));
    assign busy        = !idle;

    alu_operand_sel #(.DATA_W(DATA_W)) u_sel (
        .state   (state_q),
        .opcode  (opcode),
        .op_a    (op_a),
        .op_b    (op_b),
        .work    (work_q),
        .mcand   (mcand_q),
        .add_a   (add_a),
        .add_b   (add_b),
        .add_cin (add_cin)
    );

    alu_adder #(.WIDTH(AW)) u_adder (
        .a    (add_a),
        .b    (add_b),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout)
    );

    // Next state and next work register
    always_comb begin
        state_d = state_q;
        work_d  = work_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_mul) begin
                    state_d = ST_MUL;
                    work_d  = {{(DATA_W + 1){1'b0}}, op_a, 1'b0};
                end else if (start_div) begin
                    state_d = ST_DIV;
                    work_d  = {{(DATA_W + 2){1'b0}}, op_a};
                end
            end
            ST_MUL: begin
                // Add, then arithmetic shift right by one
                work_d = {add_sum[AW-1], add_sum, work_q[DATA_W:1]};
                if (last_step) state_d = ST_MUL_WB;
            end
            ST_DIV: begin
                // Shift left; keep the difference when it did not borrow
                if (add_cout)
                    work_d = {2'b00, add_sum[DATA_W-1:0], work_q[DATA_W-2:0], 1'b1};
                else
                    work_d = {2'b00, work_q[RES_W-2:0], 1'b0};
                if (last_step) state_d = ST_DIV_WB;
            end
            ST_MUL_WB, ST_DIV_WB: state_d = ST_IDLE;
        endcase
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            work_q  <= '0;
            mcand_q <= '0;
        end else begin
            state_q <= state_d;
            work_q  <= work_d;
            if ((state_q == ST_MUL) || (state_q == ST_DIV))
                cnt_q <= cnt_q + 1'b1;
            else
                cnt_q <= '0;
            if (start_mul || start_div)
                mcand_q <= op_b;
        end
    end

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_short) begin
                        result <= {{DATA_W{add_sum[DATA_W-1]}}, add_sum[DATA_W-1:0]};
                        done   <= 1'b1;
                    end
                end
                ST_MUL_WB: begin
                    result <= work_q[RES_W:1];
                    done   <= 1'b1;
                end
                ST_DIV_WB: begin
                    result <= work_q[RES_W-1:0];
                    done   <= 1'b1;
                end
                ST_MUL, ST_DIV: ;
            endcase
        end
    end
endmodule

// File: rtl/alu_checker.sv
module alu_checker
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          opcode,
    input logic                busy,
    input logic                done,
    input logic [2*DATA_W-1:0] result
);
    localparam int LAT   = DATA_W + 1;
    localparam int RUN_W = $clog2(LAT + 1) + 1;

    logic [RUN_W-1:0] busy_run;
    logic             opc_valid, opc_short, opc_long;

    assign opc_short = (opcode == OPC_ADD) || (opcode == OPC_SUB);
    assign opc_long  = (opcode == OPC_MUL) || (opcode == OPC_DIV);
    assign opc_valid = opc_short || opc_long;

    always_ff @(posedge clk) begin
        if (!rst_n)       busy_run <= '0;
        else if (busy)    busy_run <= busy_run + 1'b1;
        else              busy_run <= '0;
    end

    AST_INVALID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !opc_valid) |=> (!busy && !done)); // R1
    AST_SHORT_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && opc_short) |=> (done && !busy)); // R2
    AST_LONG_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && opc_long) |=> (busy && !done)); // R7
    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == RUN_W'(LAT))); // R7
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R7
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= RUN_W'(LAT)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(opc_short && !busy)) |=> !done); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result)); // R9
endmodule

bind shared_adder_alu alu_checker #(.DATA_W(DATA_W)) u_alu_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (opcode),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/tb_shared_adder_alu.sv
module tb_shared_adder_alu;
    localparam logic [2:0] C_ADD = 3'b001;
    localparam logic [2:0] C_SUB = 3'b010;
    localparam logic [2:0] C_MUL = 3'b110;
    localparam logic [2:0] C_DIV = 3'b111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  opcode = 3'b000;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [63:0] result;
    logic        busy, done;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    shared_adder_alu dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .op_a(op_a), .op_b(op_b),
        .result(result), .busy(busy), .done(done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] expect_of(input logic [2:0] op, input logic [31:0] a,
                                              input logic [31:0] b);
        logic [31:0] s;
        logic [63:0] p;
        case (op)
            C_ADD: begin s = a + b; return {{32{s[31]}}, s}; end
            C_SUB: begin s = a - b; return {{32{s[31]}}, s}; end
            C_MUL: begin p = {{32{a[31]}}, a} * {{32{b[31]}}, b}; return p; end
            default: begin
                if (b == 32'd0) return {a, 32'hFFFF_FFFF};
                return {a % b, a / b};
            end
        endcase
    endfunction

    task automatic run_short(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                             input string req);
        logic [63:0] exp;
        exp = expect_of(op, a, b);
        @(negedge clk); opcode = op; op_a = a; op_b = b;
        @(posedge clk);
        @(negedge clk); opcode = 3'b000;
        check({req, " value"}, result, exp);
        check({req, " done"}, {63'd0, done}, 64'd1);
        check({req, " busy low"}, {63'd0, busy}, 64'd0);
    endtask

    task automatic run_long(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                            input bit poke, input string req);
        logic [63:0] exp, prev;
        exp = expect_of(op, a, b);
        @(negedge clk); opcode = op; op_a = a; op_b = b;
        @(posedge clk);
        @(negedge clk); opcode = 3'b000;
        prev = result;
        check("R7 busy after start", {62'd0, busy, done}, 64'd2);
        for (int i = 0; i < 32; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (poke && i == 10) begin
                // R8: start strobe and new operands while busy
                opcode = (op == C_MUL) ? C_DIV : C_ADD;
                op_a = ~a; op_b = a ^ b ^ 32'h5A5A_0001;
            end else if (poke && i == 11) begin
                opcode = 3'b000;
            end
            if (i == 31) begin
                check("R7 still busy before last edge", {62'd0, busy, done}, 64'd2);
                check("R9 result held while busy", result, prev);
            end
        end
        @(posedge clk);
        @(negedge clk);
        check({req, " value"}, result, exp);
        check("R7 done at 33rd edge", {62'd0, busy, done}, 64'd1);
        @(posedge clk);
        @(negedge clk);
        check("R9 done one cycle", {63'd0, done}, 64'd0);
        check("R9 result holds", result, exp);
    endtask

    task automatic run_invalid(input logic [2:0] op);
        logic [63:0] prev;
        prev = result;
        @(negedge clk); opcode = op; op_a = 32'h1234_5678; op_b = 32'h9ABC_DEF0;
        @(posedge clk);
        @(negedge clk); opcode = 3'b000;
        check("R1 invalid code no busy/done", {62'd0, busy, done}, 64'd0);
        check("R1 invalid code result kept", result, prev);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [2:0]  rop;
        logic [31:0] ra, rb;
        void'($urandom(32'd20240917));
        // R10: opcodes during reset are ignored
        opcode = C_MUL; op_a = 32'd3; op_b = 32'd5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset result", result, 64'd0);
        check("R10 reset busy/done", {62'd0, busy, done}, 64'd0);
        opcode = 3'b000;
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 no start from reset", {62'd0, busy, done}, 64'd0);

        run_short(C_ADD, 32'd7, 32'hFFFF_FFF4, "R2 7+-12");
        run_short(C_ADD, 32'h7FFF_FFFF, 32'd1, "R2 wrap");
        run_short(C_ADD, 32'h0000_7FFF, 32'h0000_7FFF, "R2 small");
        run_short(C_SUB, 32'hFFFF_FFFD, 32'hFFFF_FFF4, "R3 -3--12");
        run_short(C_SUB, 32'h8000_0000, 32'd1, "R3 wrap");
        run_short(C_ADD, 32'd1, 32'd2, "R2 back-to-back");
        run_invalid(3'b000);
        run_invalid(3'b011);
        run_invalid(3'b100);
        run_invalid(3'b101);

        run_long(C_MUL, 32'h0000_0761, 32'h0000_9761, 1'b0, "R4 positive");
        run_long(C_MUL, 32'h8000_0000, 32'h8000_0000, 1'b1, "R4 min*min");
        run_long(C_MUL, 32'h7FFF_FFFF, 32'h8497_EC78, 1'b0, "R4 mixed sign");
        run_long(C_MUL, 32'hFFFF_FFFF, 32'd1, 1'b0, "R4 -1*1");
        run_long(C_DIV, 32'd10, 32'd2, 1'b1, "R5 10/2");
        run_long(C_DIV, 32'd18, 32'd5, 1'b0, "R5 18/5");
        run_long(C_DIV, 32'd5, 32'd7, 1'b0, "R5 small dividend");
        run_long(C_DIV, 32'hFFFF_FFFF, 32'd1, 1'b0, "R5 max/1");
        run_long(C_DIV, 32'd2, 32'd0, 1'b0, "R6 div by zero");
        run_long(C_DIV, 32'hDEAD_BEEF, 32'd0, 1'b1, "R6 div by zero large");

        for (int k = 0; k < 30; k++) begin
            case ($urandom % 4)
                0: rop = C_ADD;
                1: rop = C_SUB;
                2: rop = C_MUL;
                default: rop = C_DIV;
            endcase
            ra = $urandom;
            rb = $urandom;
            if (rop == C_DIV && k % 5 == 0) rb = rb >> 20;
            if (rop == C_ADD)      run_short(rop, ra, rb, "R2 random");
            else if (rop == C_SUB) run_short(rop, ra, rb, "R3 random");
            else if (rop == C_MUL) run_long(rop, ra, rb, k[0], "R4 random");
            else                   run_long(rop, ra, rb, k[0], "R5 random");
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule